// File: doc/BRIEF.md
# Eight-Bit Event Timer with Sticky Compare Flags

This block is an 8-bit up-counter that advances by one on each cycle its count strobe is high. Two compare registers are checked against the counter. A status register collects three sticky event flags: a compare match on channel A, a compare match on channel B, and counter wrap-around. Software reads and writes the counter, both compare registers and the status register over a small synchronous register bus.

The bus has an address, a read strobe, a write strobe and write data. Read data is combinational from the addressed register. The bus has no handshake: every access completes in the cycle it is presented, so nothing ever stalls.

Software clears a flag in two steps. It first reads the flag as 1, then writes 0 to that bit. A converter-start enable bit in the status register decides whether a compare-A match also sends a one-cycle start pulse to an external A/D converter.

Top module: `tmr8_timer`

## Requirements
- R1: After reset the counter reads 0x00, both compare registers read 0xFF, and the status register reads 0x0F.
- R2: Addresses are 0 = counter, 1 = compare A, 2 = compare B, 3 = status. The counter and both compare registers read back what was written. A counter write in the same cycle as a count strobe takes priority, and the written value is kept.
- R3: When the count strobe is high in a cycle, the counter increases by one at the end of that cycle. It wraps from 0xFF to 0x00.
- R4: A wrap from 0xFF to 0x00 sets the overflow flag (status bit 5). The flag is visible from the cycle after the count strobe.
- R5: A compare is evaluated in the cycle after the counter was incremented or written, or after either compare register was written. If the counter then equals compare A, flag A (bit 6) is set at the end of that cycle. If it equals compare B, flag B (bit 7) is set the same way.
- R6: While the counter and the compare registers are unchanged, a standing equality does not set a flag again.
- R7: Writing 1 to a flag bit never sets it. Status bits 3 to 0 always read as 1 and ignore writes.
- R8: A status write clears a flag bit only when two things hold: the write carries 0 in that bit, and an earlier status read returned that bit as 1 with no status write in between. Every status write cancels all earlier reads.
- R9: When a flag's set event and its clear land in the same cycle, the flag remains 1.
- R10: The converter-start output pulses for exactly one cycle, in the same cycle that flag A becomes visible. It pulses only when the enable bit was 1 during the evaluation cycle.
- R11: Status bit 4 is the converter-start enable. It reads back as written and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Count strobe, increments the counter |
| addr | input | 2 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| adc_start | output | 1 | One-cycle converter start request |

## Verification
The bench writes 0 to a flag that was never read. A design that skipped the read-before-clear rule would lose the flag at that point. The bench also writes 1 to flag bits; a design that let software set flags would show them set afterwards. It places a software clear in the exact cycle that compare A is evaluated, where a design that let the clear win would read the flag back as 0. It leaves a matching compare standing for several idle cycles and counts converter-start pulses across both settings of the enable bit. A design that re-evaluated the compare every cycle, or ignored the enable, would show extra pulses or misplaced ones.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    RA_COUNT = 2'd0,
    RA_CMPA  = 2'd1,
    RA_CMPB  = 2'd2,
    RA_STAT  = 2'd3
  } tmr8_addr_e;

  // flag index i lives at status bit FLAG_LSB + i: 0 wrap, 1 cmp A, 2 cmp B
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_LSB  = 5;
  localparam int IDX_WRAP  = 0;
  localparam int IDX_HITA  = 1;
  localparam int IDX_HITB  = 2;
  localparam int BIT_TRIG  = 4;
  localparam int NUM_CMP   = 2;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] CMP_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic         ld_cnt,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cmp_a,
  output logic [W-1:0] cmp_b,
  output logic         wrap,
  output logic         eval
);
  assign wrap = count_en && !ld_cnt && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmp_a <= CMP_RST;
      cmp_b <= CMP_RST;
      eval  <= 1'b0;
    end else begin
      if (ld_cnt)        cnt <= wdata;
      else if (count_en) cnt <= cnt + 1'b1;
      if (ld_a) cmp_a <= wdata;
      if (ld_b) cmp_b <= wdata;
      eval <= count_en | ld_cnt | ld_a | ld_b;
    end
  end
endmodule

// File: rtl/tmr8_match.sv
module tmr8_match #(
  parameter int W   = 8,
  parameter int NCH = 2
) (
  input  logic                    eval,
  input  logic [W-1:0]            cnt,
  input  logic [NCH-1:0][W-1:0]   cmp,
  output logic [NCH-1:0]          hit
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c] = eval && (cnt == cmp[c]);
  end
endmodule

// File: rtl/tmr8_status.sv
module tmr8_status
  import tmr8_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic          rd_st,
  input  logic          wr_st,
  input  logic [7:0]    wdata,
  input  logic          hit_a,
  output logic [NF-1:0] flags,
  output logic          trig_en,
  output logic          adc_start
);
  logic [NF-1:0] armed;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic clr;
    assign clr = wr_st && armed[i] && !wdata[FLAG_LSB+i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        flags[i] <= set_ev[i] | (flags[i] & ~clr);
        if (wr_st)                 armed[i] <= 1'b0;
        else if (rd_st && flags[i]) armed[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_en   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (wr_st) trig_en <= wdata[BIT_TRIG];
      adc_start <= hit_a & trig_en;
    end
  end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_en,
  input  logic [1:0]   addr,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         adc_start
);
  logic [W-1:0] cnt, cmp_a, cmp_b;
  logic         wrap, eval, trig_en;
  logic [NUM_CMP-1:0]   hit;
  logic [NUM_FLAGS-1:0] flags, set_ev;
  logic         ld_cnt, ld_a, ld_b, wr_st, rd_st;

  assign ld_cnt = wr_en && (addr == RA_COUNT);
  assign ld_a   = wr_en && (addr == RA_CMPA);
  assign ld_b   = wr_en && (addr == RA_CMPB);
  assign wr_st  = wr_en && (addr == RA_STAT);
  assign rd_st  = rd_en && (addr == RA_STAT);

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .ld_cnt(ld_cnt), .ld_a(ld_a), .ld_b(ld_b), .wdata(wdata),
    .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b), .wrap(wrap), .eval(eval)
  );

  tmr8_match #(.W(W), .NCH(NUM_CMP)) u_match (
    .eval(eval), .cnt(cnt), .cmp({cmp_b, cmp_a}), .hit(hit)
  );

  assign set_ev[IDX_WRAP] = wrap;
  assign set_ev[IDX_HITA] = hit[0];
  assign set_ev[IDX_HITB] = hit[1];

  tmr8_status #(.NF(NUM_FLAGS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .rd_st(rd_st),
    .wr_st(wr_st), .wdata(wdata[7:0]), .hit_a(hit[0]),
    .flags(flags), .trig_en(trig_en), .adc_start(adc_start)
  );

  always_comb begin
    unique case (addr)
      RA_COUNT: rdata = cnt;
      RA_CMPA:  rdata = cmp_a;
      RA_CMPB:  rdata = cmp_b;
      default: begin
        rdata = '0;
        rdata[7:0] = {flags[IDX_HITB], flags[IDX_HITA], flags[IDX_WRAP],
                      trig_en, 4'hF};
      end
    endcase
  end
endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       count_en,
  input logic [1:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       adc_start,
  input logic [2:0] flags,
  input logic       trig_en,
  input logic [7:0] cnt
);
  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (rdata[3:0] == 4'hF)); // R7

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !flags[0] && !(count_en && cnt == 8'hFF))
      |=> !flags[0]); // R7

  AST_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(wr_en && addr == 2'd3 && !wdata[6])); // R8

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && cnt == 8'hFF && !(wr_en && addr == 2'd0)) |=> flags[0]); // R4

  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (flags[1] && $past(trig_en))); // R10
endmodule

bind tmr8_timer tmr8_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .addr(addr),
  .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .adc_start(adc_start), .flags(flags), .trig_en(trig_en), .cnt(cnt)
);

// File: tb/tb_tmr8_timer.sv
module tb_tmr8_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       adc_start;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  tmr8_timer dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .adc_start(adc_start)
  );

  always @(negedge clk) if (rst_n && adc_start) pulses++;

  // vector: op[23:22] addr[21:20] data[19:12] expect[11:4] req[3:0]
  // op 0 write, 1 read+check, 2 count strobe, 3 idle
  localparam int NV = 32;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd1, 8'h03, 8'h00, 4'd2},   // cmp A = 3
    {2'd0, 2'd2, 8'h05, 8'h00, 4'd2},   // cmp B = 5
    {2'd0, 2'd0, 8'h01, 8'h00, 4'd2},   // counter = 1
    {2'd1, 2'd3, 8'h00, 8'h0F, 4'd7},   // R7 reserved ones, no flags
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},   // counter 3 -> match A
    {2'd0, 2'd3, 8'h00, 8'h00, 4'd8},   // R8 clear without read
    {2'd1, 2'd3, 8'h00, 8'h4F, 4'd5},   // R5 flag A kept
    {2'd1, 2'd0, 8'h00, 8'h03, 4'd3},   // R3 counter value
    {2'd0, 2'd3, 8'h00, 8'h00, 4'd8},   // armed clear
    {2'd1, 2'd3, 8'h00, 8'h0F, 4'd8},   // R8 cleared
    {2'd0, 2'd3, 8'hE0, 8'h00, 4'd7},   // write ones to flags
    {2'd1, 2'd3, 8'h00, 8'h0F, 4'd7},   // R7 no set
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},   // counter 5 -> match B
    {2'd1, 2'd3, 8'h00, 8'h8F, 4'd5},   // R5 flag B
    {2'd1, 2'd0, 8'h00, 8'h05, 4'd3},
    {2'd0, 2'd3, 8'h10, 8'h00, 4'd11},  // clear B, enable trigger
    {2'd1, 2'd3, 8'h00, 8'h1F, 4'd11},  // R11 enable reads back
    {2'd0, 2'd0, 8'hFE, 8'h00, 4'd2},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},   // FF -> 00
    {2'd1, 2'd3, 8'h00, 8'h3F, 4'd4},   // R4 wrap flag
    {2'd1, 2'd0, 8'h00, 8'h00, 4'd3},   // R3 wrapped to 0
    {2'd0, 2'd1, 8'h00, 8'h00, 4'd5},   // cmp A = 0 equals counter
    {2'd1, 2'd3, 8'h00, 8'h7F, 4'd5},   // R5 compare write evaluates
    {2'd0, 2'd3, 8'h10, 8'h00, 4'd8},   // clear A and wrap
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},
    {2'd1, 2'd3, 8'h00, 8'h1F, 4'd6},   // R6 standing match no retrigger
    {2'd1, 2'd1, 8'h00, 8'h00, 4'd2},   // R2 cmp A readback
    {2'd1, 2'd2, 8'h00, 8'h05, 4'd2}    // R2 cmp B readback
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic cnt1();
    @(negedge clk);
    count_en = 1'b1;
    @(posedge clk); #1;
    count_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(2'd0, 8'h00, "R1 counter");
    rd(2'd1, 8'hFF, "R1 cmpA");
    rd(2'd2, 8'hFF, "R1 cmpB");
    rd(2'd3, 8'h0F, "R1 status");

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      case (v[23:22])
        2'd0: wr(v[21:20], v[19:12]);
        2'd1: rd(v[21:20], v[11:4], tag);
        2'd2: cnt1();
        default: idle();
      endcase
      idle();
    end

    // R2 counter write beats count strobe
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h40; count_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; count_en = 1'b0;
    rd(2'd0, 8'h40, "R2 write priority");

    // R10 pulse alignment with enable set (status is 0x1F here)
    wr(2'd1, 8'h42);
    wr(2'd0, 8'h41);
    idle(); idle();
    p0 = pulses;
    cnt1();
    @(negedge clk); #1 check("R10 no pulse in eval cycle", {7'd0, adc_start}, 8'h00);
    @(negedge clk); #1 check("R10 pulse cycle", {7'd0, adc_start}, 8'h01);
    idle(); idle(); idle();
    check("R10 single pulse", 8'(pulses - p0), 8'h01);
    rd(2'd3, 8'h5F, "R10 flag A with pulse");

    // R10 gated off
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h0F, "R11 enable cleared");
    wr(2'd0, 8'h41);
    idle();
    p0 = pulses;
    cnt1();
    idle(); idle(); idle(); idle();
    check("R10 no pulse when disabled", 8'(pulses - p0), 8'h00);
    rd(2'd3, 8'h4F, "R10 flag still set");

    // R9 set and clear in same cycle (flag A armed by previous read)
    wr(2'd0, 8'h41);
    idle();
    cnt1();
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h4F, "R9 set wins");
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h0F, "R8 clear after read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule